// File: doc/BRIEF.md
# Cascadable Configuration Memory Reader

This block streams the contents of a small on-chip configuration store to a downstream loader, one beat per rising clock edge. In serial mode a single lane carries the data bit by bit, most significant bit of each byte first. In parallel mode all eight lanes carry one whole byte per beat. An address counter walks the store from location zero. It moves only while the block is selected (`ce_n` low) and released from reset (`oe_rst_n` high). Dropping either of those controls clears the counter at once and takes the block off the shared data lines.

Several readers can form one long stream. Each reader's `ceo_n` drives the `ce_n` of the next, and the clock and data lanes are shared. When a reader's counter steps past its last address, the reader lowers `ceo_n`, stops counting and disables its lanes so that the next reader can drive them. Lane drivers are modelled as a value bus plus a per-lane enable bus rather than as tri-states.

The outgoing stream has no back-pressure. There is no ready: the loader must take every beat. A lane's enable bit serves as its valid flag, and a beat is held for exactly one clock period. The store is filled through a plain synchronous write port.

Top module: `cfgmem_reader`

## Requirements
- R1: The counter advances by one on a rising `clk` edge only while `ce_n` is 0 and `oe_rst_n` is 1.
- R2: While `oe_rst_n` is 0, the counter is held at zero immediately, without waiting for a clock edge. In that state all eight bits of `dout_oe` are 0.
- R3: While `ce_n` is 1, the counter is held at zero and all eight bits of `dout_oe` are 0. Selecting the block again restarts the stream at byte 0.
- R4: `ceo_n` is 0 only when `ce_n` is 0, `oe_rst_n` is 1 and the counter has stepped past its terminal count. The terminal count is DEPTH*8-1 in serial mode and DEPTH-1 in parallel mode. After that step the counter stays past terminal count.
- R5: `ceo_n` returns to 1 with no clock edge as soon as `oe_rst_n` falls or `ce_n` rises.
- R6: In serial mode (`mode_par`=0), `dout_oe` is 8'h01. Lanes 7..1 read 0. Beat k carries bit 7-(k mod 8) of byte k/8.
- R7: In parallel mode (`mode_par`=1), `dout_oe` is 8'hFF and beat k carries byte k on `dout[7:0]`.
- R8: The output for beat k follows the k-th counting edge combinationally. Beat 0 is presented as soon as the block is enabled, before any edge.
- R9: Once the counter is past terminal count, `dout_oe` is 8'h00.
- R10: A rising edge with `wr_en`=1 stores `wr_data` at `wr_addr`, whatever the state of `ce_n` and `oe_rst_n`.
- R11: Every lane whose `dout_oe` bit is 0 reads 0 on `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, rising edge active |
| ce_n | input | 1 | Active-low select; high means standby |
| oe_rst_n | input | 1 | Active-low counter clear and lane disable |
| mode_par | input | 1 | 0 = serial on lane 0, 1 = byte-wide |
| wr_en | input | 1 | Store write strobe |
| wr_addr | input | $clog2(DEPTH) | Store write byte address |
| wr_data | input | 8 | Store write byte |
| dout | output | 8 | Lane values |
| dout_oe | output | 8 | Per-lane drive enable (valid) |
| ceo_n | output | 1 | Active-low select for the next reader |

## Verification
The hardest state to reach is the point just past terminal count in serial mode. Getting there takes DEPTH*8 uninterrupted counting edges. During those edges the select and reset controls must stay steady, or the count starts over. The stimulus clears the counter, holds both controls still and applies the exact edge count in one run. It then toggles each control without any clock edge, to show that the hand-over signal releases combinationally.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;
  localparam int LANES = 8;
  typedef logic [LANES-1:0] lane_t;
  typedef enum logic {
    MODE_SERIAL   = 1'b0,
    MODE_PARALLEL = 1'b1
  } mode_e;
endpackage

// File: rtl/cfgmem_store.sv
module cfgmem_store
  import cfgmem_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  lane_t         wr_data,
  input  logic [AW-1:0] rd_addr,
  output lane_t         rd_data
);
  lane_t cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/cfgmem_seq.sv
module cfgmem_seq
  import cfgmem_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH * LANES),
  localparam logic [CW-1:0] LAST_BIT  = CW'(DEPTH * LANES - 1),
  localparam logic [CW-1:0] LAST_BYTE = CW'(DEPTH - 1)
) (
  input  logic          clk,
  input  logic          hold_n,
  input  mode_e         mode,
  output logic [CW-1:0] cnt,
  output logic          past_tc
);
  logic [CW-1:0] last;
  logic          at_last;

  assign last    = (mode == MODE_PARALLEL) ? LAST_BYTE : LAST_BIT;
  assign at_last = (cnt == last);

  always_ff @(posedge clk or negedge hold_n) begin
    if (!hold_n) begin
      cnt     <= '0;
      past_tc <= 1'b0;
    end else if (!past_tc) begin
      if (at_last) past_tc <= 1'b1;
      else         cnt     <= cnt + 1'b1;
    end
  end

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!hold_n)
    (!past_tc && !at_last) |=> (cnt == CW'($past(cnt) + 1'b1)));

  assert_past_sticky_R4: assert property (@(posedge clk) disable iff (!hold_n)
    past_tc |=> (past_tc && $stable(cnt)));
endmodule

// File: rtl/cfgmem_lanes.sv
module cfgmem_lanes
  import cfgmem_pkg::*;
(
  input  logic  clk,
  input  logic  oe_rst_n,
  input  logic  drive,
  input  mode_e mode,
  input  logic [2:0] bit_sel,
  input  lane_t rd_data,
  output lane_t dout,
  output lane_t dout_oe
);
  logic serial_bit;
  assign serial_bit = rd_data[3'd7 - bit_sel];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic en;
    logic val;
    if (i == 0) begin : g_first
      assign en  = drive;
      assign val = (mode == MODE_PARALLEL) ? rd_data[0] : serial_bit;
    end else begin : g_rest
      assign en  = drive && (mode == MODE_PARALLEL);
      assign val = rd_data[i];
    end
    assign dout_oe[i] = en;
    assign dout[i]    = en & val;
  end

  assert_serial_single_lane_R6: assert property (@(posedge clk) disable iff (!oe_rst_n)
    (mode == MODE_SERIAL) |-> (dout[LANES-1:1] == '0 && dout_oe[LANES-1:1] == '0));

  assert_idle_lanes_zero_R11: assert property (@(posedge clk) disable iff (!oe_rst_n)
    ((dout & ~dout_oe) == '0));
endmodule

// File: rtl/cfgmem_reader.sv
module cfgmem_reader
  import cfgmem_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH * LANES)
) (
  input  logic          clk,
  input  logic          ce_n,
  input  logic          oe_rst_n,
  input  logic          mode_par,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output logic [7:0]    dout,
  output logic [7:0]    dout_oe,
  output logic          ceo_n
);
  logic          hold_n;
  logic          past_tc;
  logic [CW-1:0] cnt;
  logic [AW-1:0] rd_addr;
  lane_t         rd_data;
  mode_e         mode;

  assign hold_n  = oe_rst_n & ~ce_n;
  assign mode    = mode_par ? MODE_PARALLEL : MODE_SERIAL;
  assign rd_addr = mode_par ? cnt[AW-1:0] : cnt[CW-1:3];
  assign ceo_n   = ~(hold_n & past_tc);

  cfgmem_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  cfgmem_seq #(.DEPTH(DEPTH)) u_seq (
    .clk     (clk),
    .hold_n  (hold_n),
    .mode    (mode),
    .cnt     (cnt),
    .past_tc (past_tc)
  );

  cfgmem_lanes u_lanes (
    .clk      (clk),
    .oe_rst_n (oe_rst_n),
    .drive    (hold_n & ~past_tc),
    .mode     (mode),
    .bit_sel  (cnt[2:0]),
    .rd_data  (rd_data),
    .dout     (dout),
    .dout_oe  (dout_oe)
  );

  assert_handover_exclusive_R9: assert property (@(posedge clk) disable iff (!oe_rst_n)
    !ceo_n |-> (dout_oe == 8'h00));

  assert_standby_quiet_R3: assert property (@(posedge clk) disable iff (!oe_rst_n)
    ce_n |-> (dout_oe == 8'h00 && ceo_n));
endmodule

// File: tb/cfgmem_reader_bench.sv
module cfgmem_reader_bench;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          ce_n = 1'b1;
  logic          oe_rst_n = 1'b0;
  logic          mode_par = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [7:0]    dout;
  logic [7:0]    dout_oe;
  logic          ceo_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2ns clk = ~clk;

  cfgmem_reader #(.DEPTH(DEPTH)) u_cfgmem_reader (
    .clk(clk), .ce_n(ce_n), .oe_rst_n(oe_rst_n), .mode_par(mode_par),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dout(dout), .dout_oe(dout_oe), .ceo_n(ceo_n)
  );

  // row: {mode_par, beats[8:0], dout, dout_oe, ceo_n}
  typedef struct packed {
    logic       par;
    logic [8:0] beats;
    logic [7:0] d;
    logic [7:0] oe;
    logic       ceo;
  } row_t;

  localparam int NROWS = 12;
  localparam row_t ROWS [NROWS] = '{
    '{1'b1, 9'd0,   8'h05, 8'hFF, 1'b1},
    '{1'b1, 9'd1,   8'h2A, 8'hFF, 1'b1},
    '{1'b1, 9'd3,   8'h74, 8'hFF, 1'b1},
    '{1'b1, 9'd15,  8'h30, 8'hFF, 1'b1},
    '{1'b1, 9'd16,  8'h00, 8'h00, 1'b0},
    '{1'b1, 9'd20,  8'h00, 8'h00, 1'b0},
    '{1'b0, 9'd0,   8'h00, 8'h01, 1'b1},
    '{1'b0, 9'd5,   8'h01, 8'h01, 1'b1},
    '{1'b0, 9'd7,   8'h01, 8'h01, 1'b1},
    '{1'b0, 9'd10,  8'h01, 8'h01, 1'b1},
    '{1'b0, 9'd127, 8'h00, 8'h01, 1'b1},
    '{1'b0, 9'd128, 8'h00, 8'h00, 1'b0}
  };

  task automatic tick();
    @(posedge clk);
    #1ns;
  endtask

  task automatic check(string req, logic [16:0] act, logic [16:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got dout/oe/ceo=%h expected %h", req, act, exp);
    end
  endtask

  task automatic restart(logic par);
    oe_rst_n = 1'b0;
    ce_n     = 1'b0;
    mode_par = par;
    tick();
    oe_rst_n = 1'b1;
    #1ns;
  endtask

  initial begin
    #(400000ns);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R10: fill the store while the reader is held in reset
    tick();
    for (int i = 0; i < DEPTH; i++) begin
      wr_en = 1'b1; wr_addr = AW'(i); wr_data = 8'(i * 37 + 5);
      tick();
    end
    wr_en = 1'b0;

    // R2 reset state
    check("R2 reset", {dout, dout_oe, ceo_n}, {8'h00, 8'h00, 1'b1});

    // R1 R6 R7 R8 R4 R9 table walk
    for (int r = 0; r < NROWS; r++) begin
      restart(ROWS[r].par);
      repeat (int'(ROWS[r].beats)) tick();
      check(ROWS[r].par ? "R7 R1 R8 R4 R9 parallel" : "R6 R1 R8 R4 R9 serial",
            {dout, dout_oe, ceo_n}, {ROWS[r].d, ROWS[r].oe, ROWS[r].ceo});
    end

    // R5: leave past-terminal state without a clock edge
    restart(1'b1);
    repeat (16) tick();
    check("R4 past", {dout, dout_oe, ceo_n}, {8'h00, 8'h00, 1'b0});
    ce_n = 1'b1; #1ns;
    check("R5 ce rise", {dout, dout_oe, ceo_n}, {8'h00, 8'h00, 1'b1});
    ce_n = 1'b0; #1ns;
    check("R3 reselect restarts", {dout, dout_oe, ceo_n}, {8'h05, 8'hFF, 1'b1});
    repeat (16) tick();
    oe_rst_n = 1'b0; #1ns;
    check("R5 oe fall", {dout, dout_oe, ceo_n}, {8'h00, 8'h00, 1'b1});

    // R3 / R1: clocks during standby do not advance
    restart(1'b1);
    repeat (2) tick();
    ce_n = 1'b1;
    repeat (5) tick();
    check("R3 standby", {dout, dout_oe, ceo_n}, {8'h00, 8'h00, 1'b1});
    ce_n = 1'b0; #1ns;
    check("R1 no advance in standby", {dout, dout_oe, ceo_n}, {8'h05, 8'hFF, 1'b1});

    // R2: clocks while held in reset do not advance
    oe_rst_n = 1'b0;
    repeat (4) tick();
    oe_rst_n = 1'b1; #1ns;
    check("R2 held clear", {dout, dout_oe, ceo_n}, {8'h05, 8'hFF, 1'b1});

    // R10: write during standby, then read back
    ce_n = 1'b1;
    wr_en = 1'b1; wr_addr = '0; wr_data = 8'hC3;
    tick();
    wr_en = 1'b0;
    restart(1'b1);
    check("R10 write in standby", {dout, dout_oe, ceo_n}, {8'hC3, 8'hFF, 1'b1});
    mode_par = 1'b0; #1ns;
    check("R6 R11 serial lanes", {dout, dout_oe, ceo_n}, {8'h01, 8'h01, 1'b1});

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule